// File: doc/BRIEF.md
# NAND Bank Bus Interface

This block connects a byte-wide host request port to raw NAND flash devices placed on several external memory banks. Host software does all command sequencing, page handling and error correction; the block only turns each host byte access into one correctly timed flash bus cycle. It also holds per-bank chip-enable state and makes the flash ready/busy line readable.

A host access either targets the block's own registers or a flash bank window. The upper address bits choose the bank. The offset inside that window decides the cycle type: one offset gives a command latch cycle, another gives an address latch cycle, and any other offset gives a plain data cycle. Each flash write holds the write strobe low for a fixed number of clocks and then keeps the latch lines and data steady for one more clock. Each flash read pulses the read strobe low and captures the bus on its final low clock. Every accepted access ends with a one-cycle done pulse, an error flag and, for reads, a data byte.

Top module: `nand_bank_if`

## Requirements
- R1: After reset every chip enable is high (inactive), both strobes are high, the command and address latch lines are low, the data bus is not driven, the block reports ready, and the control register reads 0x00.
- R2: The control register (register select, host_addr[0]=0) holds two bits per bank: bit 2n enables bank n and bit 2n+1 asserts its chip select. nand_ce_n[n] is low exactly when both bits are set. The register reads back what was written.
- R3: Writing a value with all assert bits (mask 0xAA) clear drives every chip enable high and leaves the enable bits (mask 0x55) as written.
- R4: Writing 0x00 to the control register drives every chip enable high and disables every bank.
- R5: A flash write at bank offset 0x08000 is a command cycle (CLE high, ALE low), at offset 0x10000 an address cycle (ALE high, CLE low), and at any other offset a data cycle (both low). The written byte appears on nand_dq_o with nand_dq_oe high.
- R6: A flash access at bank offset 0x18000, which would raise CLE and ALE together, is rejected: done with host_err=1 one cycle after acceptance, and no strobe moves.
- R7: A flash write drives nand_we_n low for WE_LOW clocks (default 2) starting the cycle after acceptance, with CLE, ALE and data steady, then keeps CLE, ALE and the driven bus for one more clock with nand_we_n high. Done follows one clock later, when the latch lines and bus driver release.
- R8: A flash read drives nand_re_n low for RE_LOW clocks (default 2) starting the cycle after acceptance. The byte on nand_dq_i during the last low clock is returned on host_rdata with done, in the cycle that nand_re_n rises.
- R9: The ready/busy input passes through two flops to status bit 0 (register select, host_addr[0]=1). A change is seen by a status read accepted two clocks after the change. Writes to the status address have no effect.
- R10: While a flash cycle is in progress host_ready is low, and any request made then is ignored.
- R11: A flash access to a bank whose enable bit is clear is rejected with host_err=1 and no strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 1 | 1 = register access, 0 = flash bank window |
| host_addr | input | 19 | Bank index in the top bits, window offset below; bit 0 picks the register |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Block can accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Access was rejected, valid with host_done |
| host_rdata | output | 8 | Read byte, valid with host_done |
| nand_ce_n | output | 4 | Active-low chip enable per bank |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Flash data bus, outgoing |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_o |
| nand_dq_i | input | 8 | Flash data bus, incoming |
| nand_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
A wrong control register value shows on nand_ce_n in the very next cycle after the write, and again in the byte returned by the following control read. A faulty window decode or cycle state shows within a few clocks as the wrong latch line, a strobe pulse of the wrong length, a bus released too early, or a done pulse with the wrong error flag or data. A broken synchroniser shows as a status bit that changes one clock early or late relative to the ready/busy input.

// File: rtl/nand_bif_pkg.sv
// Shared types and helpers for the NAND bank bus interface.
// Assumes at most four banks so the control register fits one byte.
package nand_bif_pkg;

    // Kind of flash bus cycle chosen by the window offset.
    typedef enum logic [1:0] {
        CYC_DATA = 2'd0,
        CYC_CMD  = 2'd1,
        CYC_ADDR = 2'd2
    } cyc_kind_e;

    // States of the strobe engine.
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WLOW  = 2'd1,
        ENG_WHOLD = 2'd2,
        ENG_RLOW  = 2'd3
    } eng_state_e;

    // Result of decoding a bank window offset.
    typedef struct packed {
        cyc_kind_e kind;
        logic      clash;
    } win_dec_t;

    // Mask of all chip-select assert bits for a bank count.
    function automatic logic [7:0] assert_mask(input int nbank);
        logic [7:0] m;
        m = 8'h00;
        for (int i = 0; i < nbank; i++) begin
            m[2*i+1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_bif_ctrl_reg.sv
// Per-bank enable/assert control register and chip-enable drivers.
// Assumes NBANK <= 4; bit 2n enables bank n, bit 2n+1 asserts its select.
module nand_bif_ctrl_reg #(
    parameter int NBANK = 4,
    localparam int CW   = 2 * NBANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wdata,
    output logic [CW-1:0]    ctrl,
    output logic [NBANK-1:0] bank_en,
    output logic [NBANK-1:0] ce_n
);

    logic [CW-1:0] ctrl_q;

    // Hold the control byte; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wdata;
        end
    end

    assign ctrl = ctrl_q;

    // One enable and one chip-enable driver per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_en[b] = ctrl_q[2*b];
        assign ce_n[b]    = ~(ctrl_q[2*b] & ctrl_q[2*b+1]);
    end

    // A zero write must leave every bank disabled and deselected.
    assert_zero_write_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == '0) |=> (&ce_n && bank_en == '0));

    // Clearing all assert bits deselects every chip.
    assert_assert_clear_deselects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((8'(wdata) & nand_bif_pkg::assert_mask(NBANK)) == 8'h00)) |=> &ce_n);

endmodule

// File: rtl/nand_bif_rb_sync.sv
// Two-flop synchroniser for the flash ready/busy line.
// Assumes the input is asynchronous; output resets to 0 (busy).
module nand_bif_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_async,
    output logic rb_sync
);

    logic meta_q;
    logic sync_q;

    // Shift the pin through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= rb_async;
            sync_q <= meta_q;
        end
    end

    assign rb_sync = sync_q;

endmodule

// File: rtl/nand_bif_engine.sv
// Strobe engine: runs one flash write or read cycle per start pulse.
// Assumes start only arrives while busy is low; WE_LOW, RE_LOW >= 1.
module nand_bif_engine
    import nand_bif_pkg::*;
#(
    parameter int WE_LOW = 2,
    parameter int RE_LOW = 2,
    localparam int MAXLOW = (WE_LOW > RE_LOW) ? WE_LOW : RE_LOW,
    localparam int CNT_W  = $clog2(MAXLOW + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       is_wr,
    input  cyc_kind_e  kind,
    input  logic [7:0] wdata,
    input  logic [7:0] dq_i,
    output logic       busy,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_o,
    output logic       dq_oe,
    output logic       done,
    output logic [7:0] rdata
);

    eng_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Sequence the strobes, latch lines and bus driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            cle     <= 1'b0;
            ale     <= 1'b0;
            dq_o    <= 8'h00;
            dq_oe   <= 1'b0;
            done    <= 1'b0;
            rdata   <= 8'h00;
        end else begin
            done <= 1'b0;
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        cnt_q <= '0;
                        if (is_wr) begin
                            state_q <= ENG_WLOW;
                            we_n    <= 1'b0;
                            dq_oe   <= 1'b1;
                            dq_o    <= wdata;
                            cle     <= (kind == CYC_CMD);
                            ale     <= (kind == CYC_ADDR);
                        end else begin
                            state_q <= ENG_RLOW;
                            re_n    <= 1'b0;
                        end
                    end
                end
                ENG_WLOW: begin
                    if (cnt_q == CNT_W'(WE_LOW - 1)) begin
                        we_n    <= 1'b1;
                        state_q <= ENG_WHOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ENG_WHOLD: begin
                    cle     <= 1'b0;
                    ale     <= 1'b0;
                    dq_oe   <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ENG_IDLE;
                end
                ENG_RLOW: begin
                    if (cnt_q == CNT_W'(RE_LOW - 1)) begin
                        re_n    <= 1'b1;
                        rdata   <= dq_i;
                        done    <= 1'b1;
                        state_q <= ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ENG_IDLE);

    // Checker counters: length of the current low phase of each strobe.
    logic [CNT_W:0] we_run_q;
    logic [CNT_W:0] re_run_q;

    // Count consecutive low clocks of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            re_run_q <= '0;
        end else begin
            we_run_q <= we_n ? '0 : we_run_q + 1'b1;
            re_run_q <= re_n ? '0 : re_run_q + 1'b1;
        end
    end

    assert_latch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    assert_we_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run_q == (CNT_W+1)'(WE_LOW)));

    assert_we_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(dq_o) && dq_oe));

    assert_we_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(cle) && $stable(ale) && dq_oe));

    assert_re_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (re_run_q == (CNT_W+1)'(RE_LOW) && done));

    assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == ENG_IDLE));

endmodule

// File: rtl/nand_bank_if.sv
// NAND bank bus interface top: decodes host accesses into register
// accesses or flash cycles, rejects illegal ones, merges responses.
// Assumes 2 <= NBANK <= 4; host_req is only taken while host_ready is high.
module nand_bank_if
    import nand_bif_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int OFS_W  = 17,
    parameter int WE_LOW = 2,
    parameter int RE_LOW = 2,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ADDR_W = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_reg,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic              host_ready,
    output logic              host_done,
    output logic              host_err,
    output logic [7:0]        host_rdata,
    output logic [NBANK-1:0]  nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic              nand_rb
);

    localparam int CW = 2 * NBANK;
    localparam logic [OFS_W-1:0] CMD_OFS   = OFS_W'(1) << (OFS_W - 2);
    localparam logic [OFS_W-1:0] ADDR_OFS  = OFS_W'(1) << (OFS_W - 1);
    localparam logic [OFS_W-1:0] CLASH_OFS = CMD_OFS | ADDR_OFS;

    logic [CW-1:0]     ctrl;
    logic [NBANK-1:0]  bank_en;
    logic              rb_s;
    logic              eng_busy;
    logic              eng_done;
    logic [7:0]        eng_rdata;

    logic [BANK_W-1:0] bank_idx;
    logic [OFS_W-1:0]  ofs;
    win_dec_t          dec;
    logic              bank_ok;
    logic              host_acc;
    logic              reject;
    logic              eng_start;
    logic              ctrl_wr;
    logic [7:0]        reg_rd;

    logic              rsp_v_q;
    logic              rsp_err_q;
    logic [7:0]        rsp_data_q;

    assign bank_idx = host_addr[ADDR_W-1:OFS_W];
    assign ofs      = host_addr[OFS_W-1:0];

    // Pick the cycle kind from the window offset.
    always_comb begin
        dec.clash = (ofs == CLASH_OFS);
        if (ofs == CMD_OFS) begin
            dec.kind = CYC_CMD;
        end else if (ofs == ADDR_OFS) begin
            dec.kind = CYC_ADDR;
        end else begin
            dec.kind = CYC_DATA;
        end
    end

    // Check that the addressed bank exists and is enabled.
    always_comb begin
        bank_ok = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            if (int'(bank_idx) == b && bank_en[b]) begin
                bank_ok = 1'b1;
            end
        end
    end

    assign host_ready = ~eng_busy;
    assign host_acc   = host_req & host_ready;
    assign reject     = ~host_reg & (dec.clash | ~bank_ok);
    assign eng_start  = host_acc & ~host_reg & ~reject;
    assign ctrl_wr    = host_acc & host_reg & host_wr & ~host_addr[0];

    // Register read data: control byte or synchronised ready bit.
    always_comb begin
        if (host_reg && !host_wr) begin
            reg_rd = host_addr[0] ? {7'b0, rb_s} : 8'(ctrl);
        end else begin
            reg_rd = 8'h00;
        end
    end

    // Respond one clock after register accesses and rejected accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q    <= 1'b0;
            rsp_err_q  <= 1'b0;
            rsp_data_q <= 8'h00;
        end else begin
            rsp_v_q    <= host_acc & ~eng_start;
            rsp_err_q  <= host_acc & reject;
            rsp_data_q <= reg_rd;
        end
    end

    assign host_done  = rsp_v_q | eng_done;
    assign host_err   = rsp_err_q;
    assign host_rdata = eng_done ? eng_rdata : rsp_data_q;

    nand_bif_ctrl_reg #(.NBANK(NBANK)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wdata   (host_wdata[CW-1:0]),
        .ctrl    (ctrl),
        .bank_en (bank_en),
        .ce_n    (nand_ce_n)
    );

    nand_bif_rb_sync u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_async (nand_rb),
        .rb_sync  (rb_s)
    );

    nand_bif_engine #(.WE_LOW(WE_LOW), .RE_LOW(RE_LOW)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .is_wr (host_wr),
        .kind  (dec.kind),
        .wdata (host_wdata),
        .dq_i  (nand_dq_i),
        .busy  (eng_busy),
        .we_n  (nand_we_n),
        .re_n  (nand_re_n),
        .cle   (nand_cle),
        .ale   (nand_ale),
        .dq_o  (nand_dq_o),
        .dq_oe (nand_dq_oe),
        .done  (eng_done),
        .rdata (eng_rdata)
    );

    // A rejected access leaves both strobes idle in the next cycle.
    assert_reject_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_acc && reject) |=> (nand_we_n && nand_re_n && host_done && host_err));

    // Done and error are only seen together with a rejection.
    assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_done);

endmodule

// File: tb/tb_nand_bank_if.sv
module tb_nand_bank_if;

    localparam int NBANK  = 4;
    localparam int WE_LOW = 2;
    localparam int RE_LOW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_reg = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = 8'h00;
    logic        host_ready;
    logic        host_done;
    logic        host_err;
    logic [7:0]  host_rdata;
    logic [3:0]  nand_ce_n;
    logic        nand_cle;
    logic        nand_ale;
    logic        nand_we_n;
    logic        nand_re_n;
    logic [7:0]  nand_dq_o;
    logic        nand_dq_oe;
    logic [7:0]  nand_dq_i = 8'h00;
    logic        nand_rb = 1'b0;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit         err;
        bit         chk;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    nand_bank_if dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_reg(host_reg), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_done(host_done), .host_err(host_err),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic sb_push(bit err, bit c, logic [7:0] d, string tag);
        exp_t e;
        e.err = err; e.chk = c; e.data = d; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pop an expected response for each done pulse.
    always @(negedge clk) begin
        if (rst_n && host_done === 1'b1) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "host_err", 32'(host_err), 32'(e.err));
                if (e.chk) chk(e.tag, "host_rdata", 32'(host_rdata), 32'(e.data));
            end
        end
    end

    task automatic wait_ready();
        while (host_ready !== 1'b1) @(negedge clk);
    endtask

    task automatic reg_wr(bit sel, logic [7:0] d, string tag);
        wait_ready();
        host_req = 1; host_reg = 1; host_wr = 1; host_addr = 19'(sel); host_wdata = d;
        sb_push(0, 0, 8'h00, tag);
        @(negedge clk);
        host_req = 0;
        @(negedge clk);
    endtask

    task automatic reg_rd(bit sel, logic [7:0] exp, string tag);
        wait_ready();
        host_req = 1; host_reg = 1; host_wr = 0; host_addr = 19'(sel);
        sb_push(0, 1, exp, tag);
        @(negedge clk);
        host_req = 0;
        @(negedge clk);
    endtask

    function automatic logic [3:0] ce_of(logic [7:0] v);
        logic [3:0] r;
        for (int b = 0; b < 4; b++) r[b] = ~(v[2*b] & v[2*b+1]);
        return r;
    endfunction

    task automatic ctrl_set(logic [7:0] v, string tag);
        reg_wr(0, v, tag);
        chk(tag, "nand_ce_n", 32'(nand_ce_n), 32'(ce_of(v)));
        reg_rd(0, v, tag);
    endtask

    task automatic flash_write(int bank, logic [16:0] ofs, logic [7:0] d, bit poke, string tag);
        logic cle_e;
        logic ale_e;
        cle_e = (ofs == 17'h08000);
        ale_e = (ofs == 17'h10000);
        wait_ready();
        host_req = 1; host_reg = 0; host_wr = 1; host_addr = {2'(bank), ofs}; host_wdata = d;
        sb_push(0, 0, 8'h00, tag);
        @(negedge clk);
        host_req = 0;
        for (int n = 1; n <= WE_LOW; n++) begin
            if (n == 2) host_req = 0;
            chk(tag, "we_n low", 32'(nand_we_n), 32'h0);
            chk(tag, "cle", 32'(nand_cle), 32'(cle_e));
            chk(tag, "ale", 32'(nand_ale), 32'(ale_e));
            chk(tag, "dq_o", 32'(nand_dq_o), 32'(d));
            chk(tag, "dq_oe", 32'(nand_dq_oe), 32'h1);
            chk("R10", "host_ready busy", 32'(host_ready), 32'h0);
            if (n == 1 && poke) begin
                host_req = 1; host_reg = 1; host_wr = 1; host_addr = '0; host_wdata = 8'h00;
            end
            @(negedge clk);
        end
        host_req = 0;
        chk(tag, "we_n hold", 32'(nand_we_n), 32'h1);
        chk(tag, "cle hold", 32'(nand_cle), 32'(cle_e));
        chk(tag, "ale hold", 32'(nand_ale), 32'(ale_e));
        chk(tag, "dq_oe hold", 32'(nand_dq_oe), 32'h1);
        @(negedge clk);
        chk(tag, "release", 32'({nand_cle, nand_ale, nand_dq_oe}), 32'h0);
        chk(tag, "done", 32'(host_done), 32'h1);
        @(negedge clk);
    endtask

    task automatic flash_read(int bank, logic [16:0] ofs, logic [7:0] good, string tag);
        wait_ready();
        nand_dq_i = ~good;
        host_req = 1; host_reg = 0; host_wr = 0; host_addr = {2'(bank), ofs};
        sb_push(0, 1, good, tag);
        @(negedge clk);
        host_req = 0;
        for (int n = 1; n <= RE_LOW; n++) begin
            chk(tag, "re_n low", 32'(nand_re_n), 32'h0);
            chk(tag, "we_n idle", 32'(nand_we_n), 32'h1);
            if (n == RE_LOW) nand_dq_i = good;
            @(negedge clk);
        end
        chk(tag, "re_n rise", 32'(nand_re_n), 32'h1);
        chk(tag, "done", 32'(host_done), 32'h1);
        nand_dq_i = ~good;
        @(negedge clk);
    endtask

    task automatic flash_reject(int bank, logic [16:0] ofs, bit wr, string tag);
        wait_ready();
        host_req = 1; host_reg = 0; host_wr = wr; host_addr = {2'(bank), ofs}; host_wdata = 8'h5A;
        sb_push(1, 0, 8'h00, tag);
        @(negedge clk);
        host_req = 0;
        for (int n = 1; n <= 3; n++) begin
            chk(tag, "strobes idle", 32'({nand_we_n, nand_re_n}), 32'h3);
            chk(tag, "latches idle", 32'({nand_cle, nand_ale}), 32'h0);
            if (n == 1) chk(tag, "reject done", 32'(host_done), 32'h1);
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run is a failure but still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the pins and in the control register.
        chk("R1", "ce_n", 32'(nand_ce_n), 32'hF);
        chk("R1", "strobes", 32'({nand_we_n, nand_re_n}), 32'h3);
        chk("R1", "latches/oe", 32'({nand_cle, nand_ale, nand_dq_oe}), 32'h0);
        chk("R1", "ready", 32'(host_ready), 32'h1);
        reg_rd(0, 8'h00, "R1");

        // R2: enable+assert per bank.
        ctrl_set(8'hFF, "R2");
        ctrl_set(8'h07, "R2");
        ctrl_set(8'h9C, "R2");
        // R3: clearing assert bits keeps enables.
        ctrl_set(8'hFF, "R3");
        ctrl_set(8'h55, "R3");
        // R4: zero write disables everything.
        ctrl_set(8'h00, "R4");
        flash_reject(1, 17'h00000, 1, "R4");

        ctrl_set(8'hFF, "R2");
        // R5/R7: command, address and data cycles.
        flash_write(2, 17'h08000, 8'h90, 0, "R5");
        flash_write(2, 17'h10000, 8'h00, 0, "R5");
        flash_write(2, 17'h00123, 8'hA5, 0, "R7");
        flash_write(0, 17'h08001, 8'h3C, 0, "R5");
        // R8: reads capture the last low clock.
        flash_read(2, 17'h00000, 8'h3C, "R8");
        flash_read(1, 17'h00040, 8'hC3, "R8");
        // R6: both latch lines requested.
        flash_reject(2, 17'h18000, 1, "R6");
        flash_reject(2, 17'h18000, 0, "R6");

        // R11: disabled bank.
        ctrl_set(8'h3F, "R11");
        flash_reject(3, 17'h08000, 1, "R11");
        flash_reject(3, 17'h00000, 0, "R11");
        reg_rd(0, 8'h3F, "R11");

        // R10: request during a flash cycle is ignored.
        flash_write(1, 17'h00010, 8'h77, 1, "R10");
        reg_rd(0, 8'h3F, "R10");
        chk("R10", "ce_n", 32'(nand_ce_n), 32'(ce_of(8'h3F)));

        // R9: two-flop latency on the status bit.
        wait_ready();
        nand_rb = 1;
        host_req = 1; host_reg = 1; host_wr = 0; host_addr = 19'd1;
        sb_push(0, 1, 8'h00, "R9");
        @(negedge clk);
        sb_push(0, 1, 8'h00, "R9");
        @(negedge clk);
        sb_push(0, 1, 8'h01, "R9");
        @(negedge clk);
        host_req = 0;
        @(negedge clk);
        reg_wr(1, 8'h00, "R9");
        reg_rd(1, 8'h01, "R9");
        reg_rd(0, 8'h3F, "R9");

        repeat (4) @(negedge clk);
        chk("R1", "scoreboard drained", 32'(sb_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule